// File: doc/BRIEF.md
# Double-to-int32 modular truncating converter

This block turns a 64-bit IEEE-754 double into a 32-bit signed integer and writes it out as a sign-extended 64-bit register value. The rounding direction is always toward zero and cannot be changed. The block does not clamp values that fall outside the 32-bit range. It keeps the low 32 bits of the exact truncated integer, so large values wrap modulo 2^32. Infinities and NaNs give zero. The block also reports IEEE exception flags for the conversion.

Next to the arithmetic, a small decoder tests a 32-bit instruction word against the one fixed encoding of this operation. It also extracts the floating-point source index and the integer destination index. Operand and instruction enter together under an input valid. Result, flags, decode hit and indices come out of one register stage one cycle later. There is no backpressure.

Top module: `fcvtw_mod_conv`

## Requirements
- R1: `o_match` is 1 only when the instruction word has bits 31:25 = 1100001, bits 24:20 = 01000, bits 14:12 = 001 and bits 6:0 = 1010011. Bits 19:15 and 11:7 may hold any value.
- R2: For finite inputs, the result bits 31:0 are the operand truncated toward zero, taken as the exact two's-complement integer and reduced to its low 32 bits.
- R3: Positive infinity, negative infinity, quiet NaN and signalling NaN all give result 0 and raise the invalid flag.
- R4: A finite input whose truncated value lies outside [-2^31, 2^31-1] does not saturate. It gives the low 32 bits of the truncated integer and raises invalid.
- R5: The flags are `o_flags` = {invalid, divide-by-zero, overflow, underflow, inexact}, bit 4 down to bit 0. Bits 3..1 are always 0. Inexact is 1 only when truncation drops a nonzero fraction and invalid is 0.
- R6: `o_result[63:32]` always equals copies of `o_result[31]`.
- R7: `o_rd_idx` is instruction bits 11:7 and `o_fs_idx` is bits 19:15, both registered.
- R8: `o_valid` equals `i_valid` delayed by one cycle. When `i_valid` is 0, all data outputs keep their previous values.
- R9: While `rst_n` is low, every output is 0.
- R10: Zero of either sign gives 0 with no flags. A subnormal gives 0 with inexact only.
- R11: A finite input with unbiased exponent of 84 or more gives result 0 with invalid.
- R12: An input that truncates to exactly -2^31 is in range: result 0xFFFFFFFF80000000, no invalid. Inexact is set if a fraction was dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_valid | input | 1 | Operand and instruction present this cycle |
| i_insn | input | 32 | Instruction word to decode |
| i_op | input | 64 | Double-precision operand |
| o_valid | output | 1 | Registered copy of i_valid |
| o_match | output | 1 | Instruction word carries this operation's encoding |
| o_fs_idx | output | 5 | Floating-point source index |
| o_rd_idx | output | 5 | Integer destination index |
| o_result | output | 64 | Sign-extended wrapped 32-bit integer |
| o_flags | output | 5 | {NV, DZ, OF, UF, NX} |

## Verification
The bench sweeps every exponent code with four mantissa patterns and both signs. This covers zero, subnormal, below-one, in-range, wrapping, beyond-84, infinity and NaN regions, and an arithmetic wide-integer model separates each region's result and flag rule. Hand-picked values at ±2^31, 2^31-1, ±(2^32+5), ±0.5, -0.0 and -2^31-0.5 pin down the two range edges. They separate wrap from saturation and show where inexact is suppressed by invalid. Every single-bit flip of a matching instruction word, plus all eight rounding-mode codes, shows which fields the decoder compares and which it only extracts.

// File: rtl/fcvtw_pkg.sv
package fcvtw_pkg;

   // class of a floating-point operand after unpacking
   typedef enum logic [2:0] {
      CLS_ZERO = 3'd0,
      CLS_SUB  = 3'd1,
      CLS_NORM = 3'd2,
      CLS_INF  = 3'd3,
      CLS_NAN  = 3'd4
   } fp_cls_e;

   // IEEE exception flags, most significant first
   typedef struct packed {
      logic nv;
      logic dz;
      logic of;
      logic uf;
      logic nx;
   } fflags_t;

   localparam int FLAG_W = 5;

endpackage

// File: rtl/fcvtw_decode.sv
module fcvtw_decode #(
   parameter logic [6:0] OPC_V  = 7'b1010011,
   parameter logic [6:0] FUNC_V = 7'b1100001,
   parameter logic [4:0] SEL_V  = 5'b01000,
   parameter logic [2:0] RM_V   = 3'b001
) (
   input  logic [31:0] i_insn,
   output logic        o_hit,
   output logic [4:0]  o_src,
   output logic [4:0]  o_dst
);

   logic opc_ok, func_ok, sel_ok, rm_ok;

   always_comb begin
      opc_ok  = (i_insn[6:0]   == OPC_V);
      func_ok = (i_insn[31:25] == FUNC_V);
      sel_ok  = (i_insn[24:20] == SEL_V);
      rm_ok   = (i_insn[14:12] == RM_V);   // only static round-toward-zero decodes
      o_hit   = opc_ok & func_ok & sel_ok & rm_ok;
      o_src   = i_insn[19:15];
      o_dst   = i_insn[11:7];
   end

endmodule

// File: rtl/fcvtw_classify.sv
module fcvtw_classify
   import fcvtw_pkg::*;
#(
   parameter  int EXP_W = 11,
   parameter  int MAN_W = 52,
   localparam int FW    = 1 + EXP_W + MAN_W
) (
   input  logic [FW-1:0]    i_op,
   output logic             o_sign,
   output fp_cls_e          o_cls,
   output logic [EXP_W-1:0] o_exp,
   output logic [MAN_W:0]   o_sig
);

   localparam logic [EXP_W-1:0] EXP_TOP = '1;

   logic [MAN_W-1:0] man;
   logic             exp_zero, exp_full, man_zero;

   always_comb begin
      o_sign   = i_op[FW-1];
      o_exp    = i_op[FW-2 -: EXP_W];
      man      = i_op[MAN_W-1:0];
      exp_zero = (o_exp == '0);
      exp_full = (o_exp == EXP_TOP);
      man_zero = (man == '0);
      // hidden bit only for normal numbers
      o_sig    = {~exp_zero, man};
      if (exp_zero)
         o_cls = man_zero ? CLS_ZERO : CLS_SUB;
      else if (exp_full)
         o_cls = man_zero ? CLS_INF : CLS_NAN;
      else
         o_cls = CLS_NORM;
   end

endmodule

// File: rtl/fcvtw_trunc.sv
module fcvtw_trunc
   import fcvtw_pkg::*;
#(
   parameter int EXP_W = 11,
   parameter int MAN_W = 52,
   parameter int INT_W = 32
) (
   input  logic             i_sign,
   input  fp_cls_e          i_cls,
   input  logic [EXP_W-1:0] i_exp,
   input  logic [MAN_W:0]   i_sig,
   output logic [INT_W-1:0] o_res,
   output fflags_t          o_flags
);

   localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
   // at this exponent every bit of the kept window is below the shifted significand
   localparam int E_LIM = MAN_W + INT_W;
   localparam int PW    = MAN_W + 1 + E_LIM;
   localparam int SH_W  = $clog2(E_LIM);
   localparam int UE_W  = EXP_W + 2;

   localparam logic signed [UE_W-1:0] BIAS_S = UE_W'(BIAS);
   localparam logic signed [UE_W-1:0] TOP_S  = UE_W'(INT_W - 1);
   localparam logic signed [UE_W-1:0] LIM_S  = UE_W'(E_LIM);
   localparam logic [INT_W-1:0]       MIN_MAG = {1'b1, {(INT_W-1){1'b0}}};

   logic signed [UE_W-1:0] ue;
   logic                   below_one, beyond;
   logic [SH_W-1:0]        shamt;
   logic [PW-1:0]          wide;
   logic [INT_W-1:0]       mag_lo;
   logic                   frac_nz, out_rng;
   logic                   unused_hi;

   // magnitude alignment: significand shifted so the binary point sits at bit MAN_W
   always_comb begin
      ue        = $signed({2'b00, i_exp}) - BIAS_S;
      below_one = ue[UE_W-1];
      beyond    = (ue >= LIM_S);
      shamt     = (below_one || beyond) ? '0 : ue[SH_W-1:0];
      wide      = {{E_LIM{1'b0}}, i_sig} << shamt;
      mag_lo    = wide[MAN_W +: INT_W];
      frac_nz   = |wide[MAN_W-1:0];
      // exponent INT_W-1 leaves 2^(INT_W-1) <= |x|; only the exact negative minimum fits
      out_rng   = (ue > TOP_S) || ((ue == TOP_S) && !(i_sign && (mag_lo == MIN_MAG)));
   end

   assign unused_hi = ^wide[PW-1:MAN_W+INT_W];

   // result and flag selection per operand class
   always_comb begin
      o_res   = '0;
      o_flags = '0;
      unique case (i_cls)
         CLS_NAN, CLS_INF: o_flags.nv = 1'b1;
         CLS_SUB:          o_flags.nx = 1'b1;
         CLS_NORM: begin
            if (below_one) begin
               o_flags.nx = 1'b1;
            end else if (beyond) begin
               o_flags.nv = 1'b1;
            end else begin
               o_res      = i_sign ? (~mag_lo + 1'b1) : mag_lo;
               o_flags.nv = out_rng;
               o_flags.nx = frac_nz & ~out_rng;
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/fcvtw_mod_conv.sv
module fcvtw_mod_conv
   import fcvtw_pkg::*;
#(
   parameter  int XLEN  = 64,
   parameter  int INT_W = 32,
   parameter  int EXP_W = 11,
   parameter  int MAN_W = 52,
   localparam int FW    = 1 + EXP_W + MAN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              i_valid,
   input  logic [31:0]       i_insn,
   input  logic [FW-1:0]     i_op,
   output logic              o_valid,
   output logic              o_match,
   output logic [4:0]        o_fs_idx,
   output logic [4:0]        o_rd_idx,
   output logic [XLEN-1:0]   o_result,
   output logic [FLAG_W-1:0] o_flags
);

   // elaboration-time parameter checks
   if (XLEN < INT_W) begin : g_bad_xlen
      $error("XLEN must be at least INT_W");
   end
   if (INT_W < 2 || EXP_W < 2 || MAN_W < 1) begin : g_bad_fmt
      $error("format widths too small");
   end

   logic             dec_hit;
   logic [4:0]       dec_src, dec_dst;
   logic             op_sign;
   fp_cls_e          op_cls;
   logic [EXP_W-1:0] op_exp;
   logic [MAN_W:0]   op_sig;
   logic [INT_W-1:0] cv_res;
   fflags_t          cv_flags;
   logic [XLEN-1:0]  cv_wide;

   fcvtw_decode u_dec (
      .i_insn (i_insn),
      .o_hit  (dec_hit),
      .o_src  (dec_src),
      .o_dst  (dec_dst)
   );

   fcvtw_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .i_op   (i_op),
      .o_sign (op_sign),
      .o_cls  (op_cls),
      .o_exp  (op_exp),
      .o_sig  (op_sig)
   );

   fcvtw_trunc #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_cvt (
      .i_sign  (op_sign),
      .i_cls   (op_cls),
      .i_exp   (op_exp),
      .i_sig   (op_sig),
      .o_res   (cv_res),
      .o_flags (cv_flags)
   );

   // widening variant chosen by register width
   if (XLEN > INT_W) begin : g_sext
      assign cv_wide = {{(XLEN-INT_W){cv_res[INT_W-1]}}, cv_res};
   end else begin : g_same
      assign cv_wide = cv_res;
   end

   logic              q_valid, q_match;
   logic [4:0]        q_src, q_dst;
   logic [XLEN-1:0]   q_res;
   logic [FLAG_W-1:0] q_flags;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_match <= 1'b0;
         q_src   <= '0;
         q_dst   <= '0;
         q_res   <= '0;
         q_flags <= '0;
      end else begin
         q_valid <= i_valid;
         if (i_valid) begin
            q_match <= dec_hit;
            q_src   <= dec_src;
            q_dst   <= dec_dst;
            q_res   <= cv_wide;
            q_flags <= cv_flags;
         end
      end
   end

   assign o_valid  = q_valid;
   assign o_match  = q_match;
   assign o_fs_idx = q_src;
   assign o_rd_idx = q_dst;
   assign o_result = q_res;
   assign o_flags  = q_flags;

   // R8: output valid trails input valid by one cycle
   a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      i_valid |=> o_valid);
   a_r8_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !i_valid |=> !o_valid);
   // R8: data hold while idle
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !i_valid |=> $stable(o_result) && $stable(o_flags));
   // R3: all-ones exponent yields zero with invalid
   a_r3_special_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (i_valid && (i_op[FW-2 -: EXP_W] == '1)) |=> (o_result == '0) && o_flags[4]);
   // R5: invalid and inexact never together, unused flags stay low
   a_r5_flag_rules: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid |-> !(o_flags[4] && o_flags[0]) && (o_flags[3:1] == 3'b000));
   // R1: a non-zero-rounding code never decodes
   a_r1_rm_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (i_valid && (i_insn[14:12] != 3'b001)) |=> !o_match);
   // R7: destination index carried through the stage
   a_r7_rd_index: assert property (@(posedge clk) disable iff (!rst_n)
      i_valid |=> (o_rd_idx == $past(i_insn[11:7])));
   // R6: upper half mirrors the sign of the 32-bit result
   a_r6_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid |-> (o_result[XLEN-1:INT_W] == {(XLEN-INT_W){o_result[INT_W-1]}}));

endmodule

// File: tb/sim_fcvtw_mod_conv.sv
module sim_fcvtw_mod_conv;

   localparam logic [31:0] DEC_MASK = 32'hFFF0_707F;
   localparam logic [31:0] DEC_PAT  = 32'hC280_1053;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        i_valid;
   logic [31:0] i_insn;
   logic [63:0] i_op;
   logic        o_valid, o_match;
   logic [4:0]  o_fs_idx, o_rd_idx;
   logic [63:0] o_result;
   logic [4:0]  o_flags;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;   // 125 MHz

   fcvtw_mod_conv u0 (
      .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_insn(i_insn), .i_op(i_op),
      .o_valid(o_valid), .o_match(o_match), .o_fs_idx(o_fs_idx), .o_rd_idx(o_rd_idx),
      .o_result(o_result), .o_flags(o_flags)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wrap_up;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   // wide-integer model of the conversion
   task automatic ref_conv(input logic [63:0] x, output logic [63:0] r, output logic [4:0] f);
      logic         s;
      int           e;
      logic [159:0] mag;
      logic [159:0] lowmask;
      logic         fr, oor;
      logic [31:0]  lo;
      s = x[63];
      e = int'(x[62:52]);
      r = '0;
      f = '0;
      if (e == 2047) begin
         f = 5'b10000;
      end else if (e == 0) begin
         if (x[51:0] != '0) f = 5'b00001;
      end else begin
         e   = e - 1023;
         mag = {107'b0, 1'b1, x[51:0]};
         fr  = 1'b0;
         if (e < 0) begin
            mag = '0;
            fr  = 1'b1;
         end else if (e >= 84) begin
            mag = '0;
         end else if (e >= 52) begin
            mag = mag << (e - 52);
         end else begin
            lowmask = (160'd1 << (52 - e)) - 160'd1;
            fr  = (mag & lowmask) != '0;
            mag = mag >> (52 - e);
         end
         if (e >= 84) oor = 1'b1;
         else if (s)  oor = mag > 160'h8000_0000;
         else         oor = mag > 160'h7FFF_FFFF;
         lo = mag[31:0];
         if (s) lo = -lo;
         r = {{32{lo[31]}}, lo};
         f = {oor, 3'b000, fr & ~oor};
      end
   endtask

   task automatic drive(input logic [31:0] ins, input logic [63:0] op);
      @(negedge clk);
      i_valid = 1'b1;
      i_insn  = ins;
      i_op    = op;
      @(posedge clk);
      #1;
   endtask

   // apply one operand, compare everything against the model
   task automatic run_ref(input logic [63:0] op, input string tag);
      logic [63:0] er;
      logic [4:0]  ef;
      logic [31:0] ins;
      ins = DEC_PAT | (32'(op[9:5]) << 15) | (32'(op[4:0]) << 7);
      ref_conv(op, er, ef);
      drive(ins, op);
      check("R8 valid", 64'(o_valid), 64'd1);
      check({tag, " R2 R4 result"}, o_result, er);
      check({tag, " R5 flags"}, 64'(o_flags), 64'(ef));
      check("R6 sign extension", 64'(o_result[63:32]), 64'({32{o_result[31]}}));
   endtask

   // apply one operand, compare against hand-derived values
   task automatic run_lit(input logic [63:0] op, input logic [63:0] er, input logic [4:0] ef,
                          input string tag);
      drive(DEC_PAT, op);
      check({tag, " result"}, o_result, er);
      check({tag, " flags"}, 64'(o_flags), 64'(ef));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      wrap_up();
   end

   initial begin
      logic [63:0] keep_r;
      logic [4:0]  keep_f;
      rst_n   = 1'b0;
      i_valid = 1'b0;
      i_insn  = '0;
      i_op    = '0;
      repeat (3) @(posedge clk);
      #1;
      // R9: reset state
      check("R9 valid", 64'(o_valid), 64'd0);
      check("R9 match", 64'(o_match), 64'd0);
      check("R9 result", o_result, 64'd0);
      check("R9 flags", 64'(o_flags), 64'd0);
      check("R9 indices", 64'({o_fs_idx, o_rd_idx}), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // hand-derived edge values
      run_lit($realtobits(4294967301.0),  64'd5,                  5'b10000, "R4 +(2^32+5)");
      run_lit($realtobits(-4294967301.0), 64'hFFFF_FFFF_FFFF_FFFB, 5'b10000, "R4 -(2^32+5)");
      run_lit($realtobits(2147483648.0),  64'hFFFF_FFFF_8000_0000, 5'b10000, "R4 R6 +2^31");
      run_lit($realtobits(-2147483648.0), 64'hFFFF_FFFF_8000_0000, 5'b00000, "R12 -2^31");
      run_lit($realtobits(-2147483648.5), 64'hFFFF_FFFF_8000_0000, 5'b00001, "R12 -2^31-0.5");
      run_lit($realtobits(2147483647.0),  64'h0000_0000_7FFF_FFFF, 5'b00000, "R2 2^31-1");
      run_lit($realtobits(3000000000.0),  64'hFFFF_FFFF_B2D0_5E00, 5'b10000, "R4 3e9");
      run_lit($realtobits(8589934599.0),  64'd7,                  5'b10000, "R4 2^33+7");
      run_lit($realtobits(-1.5),          64'hFFFF_FFFF_FFFF_FFFF, 5'b00001, "R2 -1.5");
      run_lit($realtobits(0.5),           64'd0,                  5'b00001, "R2 +0.5");
      run_lit($realtobits(-0.5),          64'd0,                  5'b00001, "R2 -0.5");
      run_lit(64'h8000_0000_0000_0000,    64'd0,                  5'b00000, "R10 -0.0");
      run_lit(64'h0000_0000_0000_0001,    64'd0,                  5'b00001, "R10 subnormal");
      run_lit(64'h7FF0_0000_0000_0000,    64'd0,                  5'b10000, "R3 +inf");
      run_lit(64'hFFF0_0000_0000_0000,    64'd0,                  5'b10000, "R3 -inf");
      run_lit(64'h7FF8_0000_0000_0000,    64'd0,                  5'b10000, "R3 qNaN");
      run_lit(64'h7FF0_0000_0000_0001,    64'd0,                  5'b10000, "R3 sNaN");
      run_lit(64'h4530_0000_0000_0000,    64'd0,                  5'b10000, "R11 2^84");
      run_lit($realtobits(123456789.75),  64'd123456789,          5'b00001, "R2 fraction");

      // R8: idle cycle keeps outputs, valid drops
      keep_r = o_result;
      keep_f = o_flags;
      @(negedge clk);
      i_valid = 1'b0;
      i_op    = $realtobits(77.0);
      i_insn  = 32'h0;
      @(posedge clk);
      #1;
      check("R8 idle valid", 64'(o_valid), 64'd0);
      check("R8 hold result", o_result, keep_r);
      check("R8 hold flags", 64'(o_flags), 64'(keep_f));
      check("R8 hold match", 64'(o_match), 64'd1);

      // near-exhaustive sweep over exponent codes
      for (int ex = 0; ex < 2048; ex++) begin
         for (int mi = 0; mi < 4; mi++) begin
            for (int sg = 0; sg < 2; sg++) begin
               logic [51:0] mm;
               case (mi)
                  0: mm = 52'h0;
                  1: mm = 52'h1;
                  2: mm = 52'h8_0000_0000_0000;
                  default: mm = 52'hA_5A55_A5AC_3C33;
               endcase
               run_ref({sg[0], ex[10:0], mm}, "sweep");
            end
         end
      end

      // scaled small values around zero
      for (int k = -300; k <= 300; k++) begin
         run_ref($realtobits($itor(k) * 0.75), "R2 small");
      end

      // R1 R7: single-bit flips of a matching word
      for (int b = 0; b < 32; b++) begin
         logic [31:0] w;
         w = (DEC_PAT | (32'd13 << 15) | (32'd22 << 7)) ^ (32'd1 << b);
         drive(w, $realtobits(2.0));
         check("R1 bit flip match", 64'(o_match), 64'(((w & DEC_MASK) == DEC_PAT)));
         check("R7 rd index", 64'(o_rd_idx), 64'(w[11:7]));
         check("R7 fs index", 64'(o_fs_idx), 64'(w[19:15]));
      end
      // R1: every rounding-mode code
      for (int rm = 0; rm < 8; rm++) begin
         logic [31:0] w;
         w = (DEC_PAT & ~32'h0000_7000) | (32'(rm) << 12);
         drive(w, $realtobits(-3.25));
         check("R1 rounding field", 64'(o_match), 64'(rm == 1));
         check("R2 conversion ignores field", o_result, 64'hFFFF_FFFF_FFFF_FFFD);
      end

      @(negedge clk);
      i_valid = 1'b0;
      @(posedge clk);
      #1;
      check("R8 final idle", 64'(o_valid), 64'd0);
      wrap_up();
   end

endmodule